// File: doc/BRIEF.md
# Shared-Counter Single-Slope Conversion Controller

This block is the digital back end of a multi-channel single-slope converter. A single free-running conversion counter and a single ramp-enable output serve every channel at once. Each channel has its own comparator input, which is treated as asynchronous. When a channel's comparator rises while the ramp runs, the block captures the shared count as that channel's code. A channel whose comparator never rises before the counter tops out gets the full-scale code and an overflow flag.

A conversion starts with a one-cycle request. The controller then clears the counter for one cycle and raises the ramp enable. It counts until every channel has captured a code or the count reaches its top value, whichever comes first. It then drops the ramp and pulses done for one cycle. All codes, valid flags and overflow flags update together on that pulse. The result bank is a plain register output with no back-pressure: a reader takes the values on the done pulse or at any time before the next one, because they hold until then. The start request and done pulse are plain control pins with no handshake, and a request that arrives while a conversion runs is dropped.

Top module: `slope_adc_ctrl`

## Requirements
- R1: After reset, ramp_en_o, done_o, every valid_o and ovf_o bit, and every code in result_o are 0.
- R2: A start_i sampled high while idle begins a conversion. The counter clears in the next cycle, and ramp_en_o is high from the cycle after that. A start_i sampled while a conversion runs is ignored, and nothing restarts afterwards.
- R3: The shared counter is 0 in the first ramp cycle and rises by one in each later ramp cycle.
- R4: The code of a channel equals the count in the ramp cycle in which its comparator input first went from low to high, plus 2. The 2 is the two-stage synchronizer latency.
- R5: Only the first low-to-high comparator transition of a conversion is captured. Later toggles in the same conversion do not change the code.
- R6: A captured channel reports valid=1 and ovf=0. A channel with no capture reports code 2^M-1, valid=0 and ovf=1.
- R7: Without early completion, ramp_en_o stays high for exactly 2^M cycles. Once every channel has captured, the ramp ends after the capturing cycle, so the last rise in cycle d gives a ramp length of d+3.
- R8: done_o is a one-cycle pulse in the cycle right after the last ramp cycle. result_o, valid_o and ovf_o change only at that pulse and hold until the next one.
- R9: Channels capture independently from the one shared counter, so different channels report different codes in the same conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request, honoured only when idle |
| cmp_i | input | N_CH | Asynchronous comparator outputs, one bit per channel |
| ramp_en_o | output | 1 | High while the ramp must rise |
| done_o | output | 1 | One-cycle pulse when the result bank updates |
| result_o | output | N_CH*RES_W | Codes; channel k sits at bits [k*RES_W +: RES_W] |
| valid_o | output | N_CH | Channel captured a code in the last conversion |
| ovf_o | output | N_CH | Channel never captured; code forced to full scale |

## Verification
The embedded properties check the controller and channel rules on every cycle:
- a start only takes effect from idle;
- the counter reads zero when the ramp rises and steps by one inside the ramp;
- done never lasts two cycles;
- a captured code is frozen for the rest of its conversion;
- an uncaptured channel reads full scale with overflow.

Only the directed scenarios can show the remaining behaviour:
- the exact code offset through the synchronizer;
- the ramp length in the forced and early-finish cases;
- the limit codes around 2^M-2;
- that results hold between conversions while the comparators keep moving.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLEAR = 2'd1,
    ST_RAMP  = 2'd2,
    ST_DONE  = 2'd3
  } ssc_state_e;
endpackage

// File: rtl/ssc_edge_sync.sv
module ssc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-1:0], async_i};
  end

  // pipe_q[STAGES-1] is the synchronized level, pipe_q[STAGES] its previous value
  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/ssc_fsm.sv
module ssc_fsm
  import ssc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             all_got_i,
  output logic             clear_o,
  output logic             ramp_o,
  output logic             load_o,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  ssc_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic             exit_w;

  assign exit_w = (state_q == ST_RAMP) && ((cnt_q == CNT_TOP) || all_got_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_CLEAR;
      ST_CLEAR: state_d = ST_RAMP;
      ST_RAMP:  if (exit_w) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_CLEAR)                 cnt_q <= '0;
      else if (state_q == ST_RAMP && !exit_w)  cnt_q <= cnt_q + 1'b1;
    end
  end

  assign clear_o = (state_q == ST_CLEAR);
  assign ramp_o  = (state_q == ST_RAMP);
  assign load_o  = exit_w;
  assign done_o  = (state_q == ST_DONE);
  assign cnt_o   = cnt_q;

  // R2: a start taken in idle leads to the clear cycle
  a_r2_start_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i) |=> (state_q == ST_CLEAR));
  // R2: the ramp is only ever entered from the clear cycle
  a_r2_ramp_after_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ramp_o) |-> $past(clear_o));
  // R3: count is zero in the first ramp cycle
  a_r3_zero_at_ramp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ramp_o) |-> (cnt_q == '0));
  // R3: count steps by one inside the ramp
  a_r3_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ramp_o && !exit_w) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  // R8: done lasts a single cycle
  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/ssc_chan.sv
module ssc_chan #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             ramp_i,
  input  logic             load_i,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             got_next_o,
  output logic [CNT_W-1:0] result_o,
  output logic             valid_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CODE_FULL = {CNT_W{1'b1}};

  logic             got_q;
  logic [CNT_W-1:0] cap_q, cap_d;
  logic             hit_w;

  assign hit_w      = ramp_i & rise_i & ~got_q;
  assign got_next_o = got_q | hit_w;
  assign cap_d      = hit_w ? cnt_i : cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      got_q    <= 1'b0;
      cap_q    <= '0;
      result_o <= '0;
      valid_o  <= 1'b0;
      ovf_o    <= 1'b0;
    end else begin
      if (clear_i) got_q <= 1'b0;
      else         got_q <= got_next_o;
      cap_q <= cap_d;
      if (load_i) begin
        result_o <= got_next_o ? cap_d : CODE_FULL;
        valid_o  <= got_next_o;
        ovf_o    <= ~got_next_o;
      end
    end
  end

  // R5: once captured, the code stays frozen until the next clear
  a_r5_frozen_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (got_q && !clear_i) |=> $stable(cap_q));
  // R6: uncaptured channel reads full scale with overflow set
  a_r6_full_scale: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o) |-> (result_o == CODE_FULL && !valid_o));
  // R8: bank changes only on a load
  a_r8_bank_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(result_o) && $stable(valid_o) && $stable(ovf_o)));
endmodule

// File: rtl/slope_adc_ctrl.sv
module slope_adc_ctrl #(
  parameter int N_CH  = 4,
  parameter int RES_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [N_CH-1:0]       cmp_i,
  output logic                  ramp_en_o,
  output logic                  done_o,
  output logic [N_CH*RES_W-1:0] result_o,
  output logic [N_CH-1:0]       valid_o,
  output logic [N_CH-1:0]       ovf_o
);
  localparam int SYNC_STAGES = 2;

  logic             clear_w, ramp_w, load_w;
  logic [RES_W-1:0] cnt_w;
  logic [N_CH-1:0]  rise_w, got_next_w;

  ssc_fsm #(.CNT_W(RES_W)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .all_got_i (&got_next_w),
    .clear_o   (clear_w),
    .ramp_o    (ramp_w),
    .load_o    (load_w),
    .done_o    (done_o),
    .cnt_o     (cnt_w)
  );

  assign ramp_en_o = ramp_w;

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    ssc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (cmp_i[k]),
      .rise_o  (rise_w[k])
    );

    ssc_chan #(.CNT_W(RES_W)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clear_i    (clear_w),
      .ramp_i     (ramp_w),
      .load_i     (load_w),
      .rise_i     (rise_w[k]),
      .cnt_i      (cnt_w),
      .got_next_o (got_next_w[k]),
      .result_o   (result_o[k*RES_W +: RES_W]),
      .valid_o    (valid_o[k]),
      .ovf_o      (ovf_o[k])
    );
  end
endmodule

// File: tb/test_slope_adc_ctrl.sv
module test_slope_adc_ctrl;
  localparam int N  = 4;
  localparam int M  = 8;
  localparam int TOP = (1 << M) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N-1:0] cmp = '0;
  logic ramp_en, done;
  logic [N*M-1:0] result;
  logic [N-1:0] valid, ovf;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int rise_at [N];
  int fall_at [N];
  int rise2_at[N];
  int start_at;
  int ramp_len;

  always #2.5 clk = ~clk;

  slope_adc_ctrl #(.N_CH(N), .RES_W(M)) i_slope_adc_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmp_i(cmp),
    .ramp_en_o(ramp_en), .done_o(done), .result_o(result),
    .valid_o(valid), .ovf_o(ovf)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int code(input int ch);
    return int'(result[ch*M +: M]);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic clear_plan();
    for (int k = 0; k < N; k++) begin
      rise_at[k] = -1; fall_at[k] = -1; rise2_at[k] = -1;
    end
    start_at = -1;
  endtask

  // Runs one conversion following rise_at/fall_at/rise2_at (ramp cycle indices)
  task automatic run_conv();
    @(negedge clk);
    cmp = '0;
    repeat (3) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(ramp_en == 1'b0, "R2 clear cycle ramp low", ramp_en, 0);
    @(negedge clk);
    check(ramp_en == 1'b1, "R2 ramp high after clear", ramp_en, 1);
    ramp_len = 0;
    while (ramp_en) begin
      for (int k = 0; k < N; k++) begin
        if (rise_at[k] == ramp_len)  cmp[k] = 1'b1;
        if (fall_at[k] == ramp_len)  cmp[k] = 1'b0;
        if (rise2_at[k] == ramp_len) cmp[k] = 1'b1;
      end
      start = (start_at == ramp_len);
      check(done == 1'b0, "R8 no done during ramp", done, 0);
      ramp_len++;
      @(negedge clk);
    end
    start = 1'b0;
    check(done == 1'b1, "R8 done right after ramp", done, 1);
  endtask

  task automatic expect_ch(input int ch, input int exp_code, input bit exp_valid, input string req);
    check(code(ch) == exp_code, req, code(ch), exp_code);
    check(valid[ch] == exp_valid, req, valid[ch], exp_valid);
    check(ovf[ch] == !exp_valid, req, ovf[ch], !exp_valid);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(ramp_en == 1'b0, "R1 ramp_en", ramp_en, 0);
    check(done == 1'b0, "R1 done", done, 0);
    check(valid == '0, "R1 valid", valid, 0);
    check(ovf == '0, "R1 ovf", ovf, 0);
    check(result == '0, "R1 result", result[31:0], 0);
  endtask

  // R4 R6 R7 R9 and R2 (start ignored mid-ramp)
  task automatic t_spread();
    clear_plan();
    rise_at[0] = 5; rise_at[1] = 60; rise_at[2] = 200;
    start_at = 100;
    run_conv();
    check(ramp_len == TOP + 1, "R7 forced ramp length", ramp_len, TOP + 1);
    expect_ch(0, 7, 1'b1, "R4 ch0 code");
    expect_ch(1, 62, 1'b1, "R9 ch1 code");
    expect_ch(2, 202, 1'b1, "R4 ch2 code");
    expect_ch(3, TOP, 1'b0, "R6 ch3 overflow");
    @(negedge clk);
    check(done == 1'b0, "R8 done one cycle", done, 0);
    repeat (4) begin
      @(negedge clk);
      check(ramp_en == 1'b0, "R2 mid-ramp start ignored", ramp_en, 0);
    end
  endtask

  // R5: later toggles ignored
  task automatic t_retoggle();
    clear_plan();
    rise_at[0] = 10; fall_at[0] = 11; rise2_at[0] = 30;
    rise_at[1] = 40; fall_at[1] = 50; rise2_at[1] = 90;
    run_conv();
    expect_ch(0, 12, 1'b1, "R5 ch0 first rise kept");
    expect_ch(1, 42, 1'b1, "R5 ch1 first rise kept");
    expect_ch(2, TOP, 1'b0, "R6 ch2 overflow");
  endtask

  // R7: early finish once every channel captured
  task automatic t_early();
    clear_plan();
    rise_at[0] = 10; rise_at[1] = 20; rise_at[2] = 30; rise_at[3] = 40;
    run_conv();
    check(ramp_len == 43, "R7 early ramp length", ramp_len, 43);
    expect_ch(0, 12, 1'b1, "R9 ch0");
    expect_ch(3, 42, 1'b1, "R9 ch3");
  endtask

  // R4/R6 limits near full scale
  task automatic t_limits();
    clear_plan();
    rise_at[0] = TOP - 2; rise_at[1] = TOP - 1; rise_at[2] = 0;
    run_conv();
    check(ramp_len == TOP + 1, "R7 forced ramp length", ramp_len, TOP + 1);
    expect_ch(0, TOP, 1'b1, "R4 last capturable code");
    expect_ch(1, TOP, 1'b0, "R6 too late is overflow");
    expect_ch(2, 2, 1'b1, "R4 rise in first ramp cycle");
  endtask

  // R8: bank holds between conversions
  task automatic t_hold();
    logic [N*M-1:0] snap;
    logic [N-1:0] vsnap;
    snap = result; vsnap = valid;
    @(negedge clk);
    cmp = '1;
    repeat (5) @(negedge clk);
    cmp = '0;
    repeat (5) @(negedge clk);
    check(result == snap, "R8 result held", result[31:0], snap[31:0]);
    check(valid == vsnap, "R8 valid held", valid, vsnap);
    check(ramp_en == 1'b0, "R2 stays idle without start", ramp_en, 0);
  endtask

  initial begin
    clear_plan();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_spread();
    t_retoggle();
    t_hold();
    t_early();
    t_limits();
    t_hold();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule